// File: doc/BRIEF.md
# Byte-Serial CRC-16 Accelerator

A register-fed frame check engine. Software pushes the bytes of a frame, one per write, into a data port. The engine folds each byte into a running 16-bit check value in the same clock and keeps a saturating 12-bit count of the bytes it has taken in. A control port write with the clear bit set restarts both. The current check value and the byte count can be read back at any time through a small read selector.

The check is the 16-bit CCITT polynomial (x^16 + x^12 + x^5 + 1) in reflected form. Bits enter least significant first. The running value starts at 0xFFFF, and the readable result is the bitwise complement of the running value, with no byte swap. With these settings, a clear followed by the bytes 0xCC, 0xF5, 0xF1, 0xA7 gives the start-up self-test answer: a result of 0x51DF and a count of 4.

Top module: `bcrc16_engine`

## Requirements
- R1: After the synchronous reset `rst`, the count reads 0 and the result reads 0x0000 (running value 0xFFFF, complemented).
- R2: A control write (`ctrl_we`) with bit 15 of `ctrl_wdata` set restores the running value to 0xFFFF and the count to 0, seen from the next cycle.
- R3: A control write with bit 15 clear changes neither the result nor the count.
- R4: A data write (`data_we`) absorbs bits 7:0 of `data_wdata` and ignores bits 15:8. Each such write adds one to the count.
- R5: With `rd_sel` = 0 (control), `rd_data` holds the count in bits 11:0 and zeros in bits 15:12.
- R6: After a clear and the bytes 0xCC, 0xF5, 0xF1, 0xA7, the count reads 4 and the result reads 0x51DF.
- R7: Each byte updates the running value with the reflected polynomial 0x8408, least significant bit first. With `rd_sel` = 2, the result reads as the complement of the running value.
- R8: The count stops at 0xFFF and does not wrap. The check value keeps absorbing bytes after the count saturates.
- R9: When a clear and a data write occur in the same cycle, the clear wins and the byte is dropped: the next cycle shows count 0 and result 0x0000.
- R10: Data writes on consecutive cycles are all absorbed, with no stall.
- R11: `rd_sel` = 1 (data port, write-only) and `rd_sel` = 3 both read 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write value; bit 15 is the clear |
| data_we | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Data write value; the low byte is absorbed |
| rd_sel | input | 2 | Read select: 0 control/count, 1 data, 2 result, 3 unused |
| rd_data | output | 16 | Combinational read value for `rd_sel` |

## Verification
The checker assumes that `ctrl_we` and `data_we` are known and stable across each rising edge, and that a clear is signalled only by bit 15 of a control write. The bench meets this by changing every input on the falling edge. It reads through `rd_sel` after the design has settled, and drives the clear-and-data collision as two strobes raised on the same falling edge. The saturation run feeds just over 4095 bytes, so the count reaches its ceiling while the stimulus stays within the bench's cycle limit.

// File: rtl/bcrc_pkg.sv
package bcrc_pkg;
    localparam int CRC_W    = 16;
    localparam int BYTE_W   = 8;
    localparam int CNT_W    = 12;
    localparam int REG_W    = 16;
    localparam int CLR_BIT  = 15;
    localparam logic [CRC_W-1:0] POLY_REFL = 16'h8408;
    localparam logic [CRC_W-1:0] SEED      = 16'hFFFF;
    localparam logic [CRC_W-1:0] OUT_MASK  = 16'hFFFF;

    typedef enum logic [1:0] {
        SEL_CTRL   = 2'd0,
        SEL_DATA   = 2'd1,
        SEL_RESULT = 2'd2,
        SEL_NONE   = 2'd3
    } rd_sel_e;

    typedef struct packed {
        logic             clear;
        logic             absorb;
        logic [BYTE_W-1:0] byte_v;
    } bcrc_cmd_t;

    function automatic logic [REG_W-1:0] pack_ctrl(input logic [CNT_W-1:0] cnt);
        logic [REG_W-1:0] v;
        v = '0;
        v[CNT_W-1:0] = cnt;
        return v;
    endfunction
endpackage

// File: rtl/bcrc_byte_step.sv
module bcrc_byte_step
    import bcrc_pkg::*;
#(
    parameter int W = CRC_W,
    parameter int B = BYTE_W,
    parameter logic [W-1:0] POLY = POLY_REFL
) (
    input  logic [W-1:0] crc_i,
    input  logic [B-1:0] byte_i,
    output logic [W-1:0] crc_o
);
    logic [W-1:0] stage [0:B];

    assign stage[0] = crc_i;

    for (genvar i = 0; i < B; i++) begin : g_bit
        logic fb;
        assign fb = stage[i][0] ^ byte_i[i];
        assign stage[i+1] = fb ? ((stage[i] >> 1) ^ POLY) : (stage[i] >> 1);
    end

    assign crc_o = stage[B];
endmodule

// File: rtl/bcrc_sat_counter.sv
module bcrc_sat_counter #(
    parameter int N = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         inc,
    output logic [N-1:0] count
);
    localparam logic [N-1:0] TOP = {N{1'b1}};

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
        end else if (inc && count != TOP) begin
            count <= count + 1'b1;
        end
    end
endmodule

// File: rtl/bcrc_read_mux.sv
module bcrc_read_mux
    import bcrc_pkg::*;
#(
    parameter int W = REG_W,
    parameter int N = CNT_W
) (
    input  logic [1:0]   sel,
    input  logic [N-1:0] count,
    input  logic [W-1:0] result,
    output logic [W-1:0] rdata
);
    always_comb begin
        unique case (rd_sel_e'(sel))
            SEL_CTRL:   rdata = pack_ctrl(count);
            SEL_RESULT: rdata = result;
            default:    rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcrc16_engine.sv
module bcrc16_engine
    import bcrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ctrl_we,
    input  logic [REG_W-1:0]  ctrl_wdata,
    input  logic              data_we,
    input  logic [REG_W-1:0]  data_wdata,
    input  logic [1:0]        rd_sel,
    output logic [REG_W-1:0]  rd_data
);
    bcrc_cmd_t        cmd;
    logic [CRC_W-1:0] crc_q;
    logic [CRC_W-1:0] crc_next;
    logic [CNT_W-1:0] cnt_q;

    always_comb begin
        cmd.clear  = ctrl_we && ctrl_wdata[CLR_BIT];
        cmd.absorb = data_we && !cmd.clear;
        cmd.byte_v = data_wdata[BYTE_W-1:0];
    end

    bcrc_byte_step #(.W(CRC_W), .B(BYTE_W), .POLY(POLY_REFL)) u_step (
        .crc_i  (crc_q),
        .byte_i (cmd.byte_v),
        .crc_o  (crc_next)
    );

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            crc_q <= SEED;
        end else if (cmd.absorb) begin
            crc_q <= crc_next;
        end
    end

    bcrc_sat_counter #(.N(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clear (cmd.clear),
        .inc   (cmd.absorb),
        .count (cnt_q)
    );

    bcrc_read_mux #(.W(REG_W), .N(CNT_W)) u_rd (
        .sel    (rd_sel),
        .count  (cnt_q),
        .result (crc_q ^ OUT_MASK),
        .rdata  (rd_data)
    );
endmodule

// File: rtl/bcrc16_engine_chk.sv
module bcrc16_engine_chk
    import bcrc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ctrl_we,
    input logic [REG_W-1:0]  ctrl_wdata,
    input logic              data_we,
    input logic [1:0]        rd_sel,
    input logic [REG_W-1:0]  rd_data,
    input logic [CRC_W-1:0]  crc_q,
    input logic [CNT_W-1:0]  cnt_q
);
    logic clr;
    assign clr = ctrl_we && ctrl_wdata[CLR_BIT];

    p_clear_r2: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt_q == '0 && crc_q == SEED));

    p_idle_r3: assert property (@(posedge clk) disable iff (rst)
        (!clr && !data_we) |=> ($stable(cnt_q) && $stable(crc_q)));

    p_count_step_r4: assert property (@(posedge clk) disable iff (rst)
        (data_we && !clr && cnt_q != {CNT_W{1'b1}}) |=> (cnt_q == $past(cnt_q) + 1'b1));

    p_ctrl_upper_r5: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SEL_CTRL) |-> (rd_data[REG_W-1:CNT_W] == '0));

    p_no_overflow_r8: assert property (@(posedge clk) disable iff (rst)
        (cnt_q == {CNT_W{1'b1}} && !clr) |=> (cnt_q == {CNT_W{1'b1}}));

    p_clear_wins_r9: assert property (@(posedge clk) disable iff (rst)
        (clr && data_we) |=> (cnt_q == '0 && crc_q == SEED));

    p_unused_zero_r11: assert property (@(posedge clk) disable iff (rst)
        (rd_sel == SEL_NONE || rd_sel == SEL_DATA) |-> (rd_data == '0));
endmodule

bind bcrc16_engine bcrc16_engine_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (ctrl_wdata),
    .data_we    (data_we),
    .rd_sel     (rd_sel),
    .rd_data    (rd_data),
    .crc_q      (crc_q),
    .cnt_q      (cnt_q)
);

// File: tb/bcrc16_engine_bench.sv
module bcrc16_engine_bench;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 150000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        data_we = 1'b0;
    logic [15:0] data_wdata = '0;
    logic [1:0]  rd_sel = 2'd0;
    logic [15:0] rd_data;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    bcrc16_engine u_bcrc16_engine (
        .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .data_we(data_we), .data_wdata(data_wdata), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    logic [15:0] m_crc;
    int          m_cnt;

    function automatic logic [15:0] ref_add(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r;
        r = c ^ {8'h00, b};
        for (int k = 0; k < 8; k++) begin
            if (r[0]) r = (r >> 1) ^ 16'h8408;
            else      r = r >> 1;
        end
        return r;
    endfunction

    typedef struct {
        logic [15:0] exp;
        string       tag;
    } item_t;

    item_t q[$];
    event  rd_ev;

    // monitor: pops expectations and compares against the read port
    initial begin
        forever begin
            @(rd_ev);
            while (q.size() > 0) begin
                item_t it;
                it = q.pop_front();
                checks++;
                if (rd_data !== it.exp) begin
                    failures++;
                    $display("FAIL %s actual=%h expected=%h", it.tag, rd_data, it.exp);
                end
            end
        end
    end

    task automatic expect_rd(input logic [1:0] sel, input logic [15:0] exp, input string tag);
        item_t it;
        rd_sel = sel;
        #1;
        it.exp = exp;
        it.tag = tag;
        q.push_back(it);
        -> rd_ev;
        wait (q.size() == 0);
    endtask

    task automatic expect_state(input string tag);
        expect_rd(2'd0, 16'(m_cnt), {tag, " count"});
        expect_rd(2'd2, m_crc ^ 16'hFFFF, {tag, " result"});
    endtask

    task automatic put_byte(input logic [15:0] w);
        data_we = 1'b1;
        data_wdata = w;
        if (m_cnt < 4095) m_cnt++;
        m_crc = ref_add(m_crc, w[7:0]);
        @(negedge clk);
        data_we = 1'b0;
    endtask

    task automatic do_clear();
        ctrl_we = 1'b1;
        ctrl_wdata = 16'h8000;
        m_crc = 16'hFFFF;
        m_cnt = 0;
        @(negedge clk);
        ctrl_we = 1'b0;
        ctrl_wdata = '0;
    endtask

    initial begin
        m_crc = 16'hFFFF;
        m_cnt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state, R5 upper control bits
        expect_rd(2'd0, 16'h0000, "R1 count after reset");
        expect_rd(2'd2, 16'h0000, "R1 result after reset");

        // R6 / R10 self-test vector, back to back
        do_clear();
        put_byte(16'h00CC);
        put_byte(16'h00F5);
        put_byte(16'h00F1);
        put_byte(16'h00A7);
        expect_rd(2'd0, 16'h0004, "R6 self-test count");
        expect_rd(2'd2, 16'h51DF, "R6 self-test result");
        expect_rd(2'd2, m_crc ^ 16'hFFFF, "R7 model agrees on self-test");

        // R11 data and unused selects
        expect_rd(2'd1, 16'h0000, "R11 data port reads zero");
        expect_rd(2'd3, 16'h0000, "R11 unused select reads zero");

        // R3 control write without the clear bit
        ctrl_we = 1'b1;
        ctrl_wdata = 16'h7FFF;
        @(negedge clk);
        ctrl_we = 1'b0;
        expect_rd(2'd0, 16'h0004, "R3 count kept");
        expect_rd(2'd2, 16'h51DF, "R3 result kept");

        // R2 clear
        do_clear();
        expect_rd(2'd0, 16'h0000, "R2 count cleared");
        expect_rd(2'd2, 16'h0000, "R2 result cleared");

        // R4 upper data bits ignored
        put_byte(16'hAB12);
        expect_state("R4 upper bits ignored");
        do_clear();
        put_byte(16'h0012);
        expect_state("R4 low byte only");

        // R7 distinct patterns, gaps between writes
        do_clear();
        put_byte(16'h0000);
        @(negedge clk);
        put_byte(16'h00FF);
        @(negedge clk);
        @(negedge clk);
        put_byte(16'h0055);
        put_byte(16'h0080);
        put_byte(16'h0001);
        expect_state("R7 mixed pattern");

        // R9 clear and data write in the same cycle
        put_byte(16'h0033);
        ctrl_we = 1'b1;
        ctrl_wdata = 16'h8000;
        data_we = 1'b1;
        data_wdata = 16'h0099;
        @(negedge clk);
        ctrl_we = 1'b0;
        data_we = 1'b0;
        m_crc = 16'hFFFF;
        m_cnt = 0;
        expect_rd(2'd0, 16'h0000, "R9 count after collision");
        expect_rd(2'd2, 16'h0000, "R9 result after collision");

        // R8 saturation with a long back-to-back stream (R10)
        do_clear();
        for (int i = 0; i < 4095; i++) put_byte(16'(i * 7 + 3));
        expect_rd(2'd0, 16'h0FFF, "R8 count at ceiling");
        expect_state("R10 long stream");
        put_byte(16'h005A);
        put_byte(16'h00C3);
        put_byte(16'h0011);
        expect_rd(2'd0, 16'h0FFF, "R8 count held, no wrap");
        expect_rd(2'd2, m_crc ^ 16'hFFFF, "R8 result still absorbing");

        // R1 reset again mid-frame
        put_byte(16'h0042);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        m_crc = 16'hFFFF;
        m_cnt = 0;
        expect_rd(2'd0, 16'h0000, "R1 count after second reset");
        expect_rd(2'd2, 16'h0000, "R1 result after second reset");

        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule